// File: doc/BRIEF.md
# Sticky Lost-Event Flag Collector with Masked Request Line

This block gathers per-channel overrun pulses from an event scheduler. A channel raises an overrun when it is retriggered before its earlier event has gone out. Each pulse sets that channel's bit in a sticky flag register, and the bit stays set until software reads the register or the module is reset. A reading returns the register contents as they stood before the clear.

A per-channel enable mask sits after the flag register. A single request line is the OR of the flagged channels that the mask enables. Because the mask acts after the latch, disabling a flagged channel removes it from the request line as soon as the new mask is loaded. A test strobe samples the request line into a response bit that the command logic returns to the host.

The inputs are the overrun pulses, the command strobes from the register interface, and a module-reset strobe. Command decoding is done elsewhere.

Top module: `lost_event_flag_unit`

## Requirements
- R1: An overrun pulse on channel i sets bit i of the flag register (channel 0 at bit 0, the LSB) at the next clock edge. A 1 bit means that channel has lost an event.
- R2: Flag bits are sticky. Further overruns on other channels accumulate, and only a read strobe, a module-reset strobe or `rstN` clears them. Mask writes and test strobes leave the flags unchanged.
- R3: A read strobe returns the pre-clear register contents on `flagReadData` one cycle later, and clears the register at that same edge.
- R4: An overrun that arrives in the same cycle as a read strobe is kept in the register after the clear. It is not part of that read's data.
- R5: A mask write loads `maskWrData` into the mask at the next edge, and `maskValue` shows it from then on. A mask bit of 1 enables that channel's request and 0 masks it.
- R6: `lamLine` is 1 exactly when some flagged channel is enabled by the mask. It follows a flag or mask change with no extra cycle, so masking a flagged channel drops the line right after the mask-write edge.
- R7: A test strobe captures the current `lamLine` into `testQ` at the next edge. `testQ` holds that value until the next test strobe.
- R8: A module-reset strobe clears the flags, masks every channel, and zeroes `flagReadData` and `testQ`. It overrides a same-cycle overrun, mask write or read.
- R9: Asynchronous `rstN` low puts the block in the same state as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| overrunPulse | input | NCH | Per-channel lost-event pulses |
| flagReadStb | input | 1 | Read-and-clear command for the flag register |
| maskWriteStb | input | 1 | Mask write command |
| maskWrData | input | NCH | New mask value |
| testStb | input | 1 | Sample the request line for the test response |
| modResetStb | input | 1 | Module-reset command |
| flagReadData | output | NCH | Flag contents captured by the last read |
| maskValue | output | NCH | Current mask, for read-back |
| lamLine | output | 1 | Module request line |
| testQ | output | 1 | Test response: request line state at the last test strobe |

## Verification
Every register result appears one edge after its strobe. This covers the captured read data, the cleared flags, the loaded mask, the test response and the strobe reset. `lamLine` adds no further stage: it reflects a new flag or mask right after the edge that loads it. The bench drives each stimulus one time unit after a rising edge, lets exactly one edge pass, and samples one time unit after it. It then checks that the read result and the reopened register split a same-cycle overrun correctly, and that `testQ` holds between strobes.

// File: rtl/lam_pkg.sv
package lam_pkg;
  typedef struct packed {
    logic wipe;
    logic clearFlags;
    logic captureRead;
    logic loadMask;
    logic sampleTest;
  } lamCmd_t;
endpackage

// File: rtl/lam_ctrl.sv
module lam_ctrl
  import lam_pkg::*;
(
  input  logic    flagReadStb,
  input  logic    maskWriteStb,
  input  logic    testStb,
  input  logic    modResetStb,
  output lamCmd_t cmd
);
  // Module reset dominates; the datapath gives wipe top priority.
  always_comb begin
    cmd.wipe        = modResetStb;
    cmd.clearFlags  = flagReadStb;
    cmd.captureRead = flagReadStb;
    cmd.loadMask    = maskWriteStb;
    cmd.sampleTest  = testStb;
  end
endmodule

// File: rtl/lam_datapath.sv
module lam_datapath
  import lam_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  lamCmd_t        cmd,
  input  logic [NCH-1:0] overrunPulse,
  input  logic [NCH-1:0] maskWrData,
  output logic [NCH-1:0] flagReadData,
  output logic [NCH-1:0] maskValue,
  output logic           lamLine,
  output logic           testQ
);
  logic [NCH-1:0] flags;
  logic [NCH-1:0] flagsBase;

  // A read clears old flags but new overruns in the same cycle survive.
  assign flagsBase = cmd.clearFlags ? '0 : flags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags        <= '0;
      maskValue    <= '0;
      flagReadData <= '0;
      testQ        <= 1'b0;
    end else if (cmd.wipe) begin
      flags        <= '0;
      maskValue    <= '0;
      flagReadData <= '0;
      testQ        <= 1'b0;
    end else begin
      flags <= flagsBase | overrunPulse;
      if (cmd.captureRead) flagReadData <= flags;
      if (cmd.loadMask)    maskValue    <= maskWrData;
      if (cmd.sampleTest)  testQ        <= lamLine;
    end
  end

  // Mask sits after the latch so it acts at once.
  assign lamLine = |(flags & maskValue);

  assert_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.wipe) |=> ((flags & $past(overrunPulse)) == $past(overrunPulse)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clearFlags && !cmd.wipe) |=> ((flags & $past(flags)) == $past(flags)));

  assert_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.captureRead && !cmd.wipe) |=> (flagReadData == $past(flags)));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    lamLine |-> (maskValue != '0) && (flags != '0));

  assert_test_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.sampleTest && !cmd.wipe) |=> (testQ == $past(lamLine)));

  assert_wipe_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wipe |=> (flags == '0) && (maskValue == '0) && !testQ);
endmodule

// File: rtl/lost_event_flag_unit.sv
module lost_event_flag_unit
  import lam_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] overrunPulse,
  input  logic           flagReadStb,
  input  logic           maskWriteStb,
  input  logic [NCH-1:0] maskWrData,
  input  logic           testStb,
  input  logic           modResetStb,
  output logic [NCH-1:0] flagReadData,
  output logic [NCH-1:0] maskValue,
  output logic           lamLine,
  output logic           testQ
);
  lamCmd_t cmd;

  lam_ctrl u_ctrl (
    .flagReadStb (flagReadStb),
    .maskWriteStb(maskWriteStb),
    .testStb     (testStb),
    .modResetStb (modResetStb),
    .cmd         (cmd)
  );

  lam_datapath #(.NCH(NCH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .overrunPulse(overrunPulse),
    .maskWrData  (maskWrData),
    .flagReadData(flagReadData),
    .maskValue   (maskValue),
    .lamLine     (lamLine),
    .testQ       (testQ)
  );
endmodule

// File: tb/lost_event_flag_unit_tb.sv
module lost_event_flag_unit_tb;
  localparam int NCH = 16;
  localparam time CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] overrunPulse = '0;
  logic           flagReadStb = 1'b0;
  logic           maskWriteStb = 1'b0;
  logic [NCH-1:0] maskWrData = '0;
  logic           testStb = 1'b0;
  logic           modResetStb = 1'b0;
  logic [NCH-1:0] flagReadData;
  logic [NCH-1:0] maskValue;
  logic           lamLine;
  logic           testQ;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lost_event_flag_unit #(.NCH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .overrunPulse(overrunPulse),
    .flagReadStb(flagReadStb), .maskWriteStb(maskWriteStb),
    .maskWrData(maskWrData), .testStb(testStb), .modResetStb(modResetStb),
    .flagReadData(flagReadData), .maskValue(maskValue),
    .lamLine(lamLine), .testQ(testQ)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs change 1 time unit after a rising edge; one edge passes; sample after it.
  task automatic step();
    @(posedge clk); #1;
    overrunPulse = '0; flagReadStb = 0; maskWriteStb = 0;
    testStb = 0; modResetStb = 0;
  endtask

  task automatic doRead(output logic [NCH-1:0] val);
    flagReadStb = 1; step(); val = flagReadData;
  endtask

  task automatic writeMask(input logic [NCH-1:0] m);
    maskWrData = m; maskWriteStb = 1; step();
  endtask

  task automatic t_reset_state();
    logic [NCH-1:0] v;
    chk("R9 mask after rstN", 32'(maskValue), 0);
    chk("R9 lamLine after rstN", 32'(lamLine), 0);
    chk("R9 testQ after rstN", 32'(testQ), 0);
    doRead(v);
    chk("R9 flags after rstN", 32'(v), 0);
  endtask

  task automatic t_set_and_clear();
    logic [NCH-1:0] v;
    overrunPulse = 16'h0008; step();
    overrunPulse = 16'h8000; step();
    step();
    doRead(v);
    chk("R1/R2 accumulated flags ch3,ch15", 32'(v), 32'h8008);
    doRead(v);
    chk("R3 register cleared by read", 32'(v), 0);
  endtask

  task automatic t_sticky();
    logic [NCH-1:0] v;
    overrunPulse = 16'h0001; step();
    writeMask(16'h00F0);
    testStb = 1; step();
    repeat (3) step();
    doRead(v);
    chk("R2 flag survives mask write and test", 32'(v), 32'h0001);
    writeMask('0);
  endtask

  task automatic t_collide();
    logic [NCH-1:0] v;
    overrunPulse = 16'h0020; step();
    overrunPulse = 16'h0080; doRead(v);
    chk("R3 read returns pre-clear value", 32'(v), 32'h0020);
    doRead(v);
    chk("R4 same-cycle overrun kept", 32'(v), 32'h0080);
  endtask

  task automatic t_mask();
    logic [NCH-1:0] v;
    writeMask(16'h0004);
    chk("R5 mask readback", 32'(maskValue), 32'h0004);
    overrunPulse = 16'h0200; step();
    chk("R6 masked channel keeps line low", 32'(lamLine), 0);
    overrunPulse = 16'h0004; step();
    chk("R6 enabled flag raises line at once", 32'(lamLine), 1);
    writeMask(16'h0000);
    chk("R6 masking drops line at once", 32'(lamLine), 0);
    chk("R5 mask readback zero", 32'(maskValue), 0);
    writeMask(16'h0200);
    chk("R6 enabling flagged channel raises line", 32'(lamLine), 1);
    doRead(v);
    chk("R6 line low after read-clear", 32'(lamLine), 0);
  endtask

  task automatic t_test();
    logic [NCH-1:0] v;
    overrunPulse = 16'h0200; step();
    testStb = 1; step();
    chk("R7 testQ captures high line", 32'(testQ), 1);
    doRead(v);
    step();
    chk("R7 testQ holds between strobes", 32'(testQ), 1);
    testStb = 1; step();
    chk("R7 testQ captures low line", 32'(testQ), 0);
  endtask

  task automatic t_modreset();
    logic [NCH-1:0] v;
    writeMask(16'hFFFF);
    overrunPulse = 16'h1111; step();
    testStb = 1; step();
    overrunPulse = 16'h0002; maskWrData = 16'hFFFF; maskWriteStb = 1;
    modResetStb = 1; step();
    chk("R8 all channels masked", 32'(maskValue), 0);
    chk("R8 line low", 32'(lamLine), 0);
    chk("R8 testQ cleared", 32'(testQ), 0);
    chk("R8 read data cleared", 32'(flagReadData), 0);
    doRead(v);
    chk("R8 flags cleared despite overrun", 32'(v), 0);
  endtask

  task automatic t_async_reset();
    logic [NCH-1:0] v;
    writeMask(16'h0FF0);
    overrunPulse = 16'h0100; step();
    #2 rstN = 0; #2;
    chk("R9 async mask clear", 32'(maskValue), 0);
    chk("R9 async line low", 32'(lamLine), 0);
    @(negedge clk); rstN = 1;
    step();
    doRead(v);
    chk("R9 async flags cleared", 32'(v), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    step();
    t_reset_state();
    t_set_and_clear();
    t_sticky();
    t_collide();
    t_mask();
    t_test();
    t_modreset();
    t_async_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule